// File: doc/BRIEF.md
# Bitmask Interrupt Controller

This block collects up to 32 interrupt lines for a small in-order processor and decides when the processor enters its handler. External request lines, a timer event and two internal fault sources set sticky pending bits. A mask register disables lines: a 1 means the line is disabled. Software writes the mask through an update port that shows the old value in the same cycle. A build-time constant marks lines that can never be enabled.

The processor is modelled by a few strobes: an instruction-boundary strobe with the current program counter, an acknowledge for an offered entry, and a return request. An entry happens at a boundary when no handler is running and at least one line is both pending and enabled. On entry the controller offers the handler address, the saved return address and a bitmask of every serviced line, and it keeps all three steady until the processor acknowledges. The same bitmask drives the end-of-interrupt outputs until the handler returns. A single entry can therefore service several lines.

An internal fault whose line cannot be serviced sets a sticky halt instead of a pending bit. This happens when the line is masked or a handler is already running.

Top module: `irq_bitmask_ctrl`

## Requirements
- R1: Any asserted bit of `irq_req` in a cycle sets the matching pending bit at that clock edge. The bit stays set with no further assertion until an entry services it.
- R2: After a synchronous reset the mask reads all ones, nothing is pending, and `take_req`, `eoi`, `active`, `halt` and `redir_valid` are 0. `redir_pc` reads `RESET_ADDR`.
- R3: Lines set in `PERM_MASK` always read 1 in the mask. They never become pending, so they never appear in `take_bits` or `eoi`.
- R4: An entry starts only in a cycle with `insn_bound` high, no handler active, `halt` low and a nonzero value of pending AND NOT mask. `take_req` and `active` then rise at the next edge.
- R5: On entry, `take_bits` and `eoi` both equal the pending AND NOT mask value sampled in the boundary cycle. Those bits leave pending. Pending bits that are masked stay pending.
- R6: While `mask_we` is high, `mask_rdata` still shows the old mask. From the next edge on, the mask equals `mask_wdata` OR `PERM_MASK`.
- R7: During an offer, `take_vec` equals `HANDLER_ADDR` and `take_ret` equals the `cur_pc` of the boundary cycle. `take_req`, `take_bits` and `take_ret` hold steady until the cycle `take_ack` is high; `take_req` falls at the following edge.
- R8: A `ret_req` after the acknowledge has three effects at the next edge: `eoi` goes to 0, `active` goes to 0, and `redir_valid` pulses for one cycle with `redir_pc` equal to the saved return address. A `ret_req` while idle or during an offer has no effect.
- R9: A line raised while a handler is active stays pending and is not taken at boundaries inside the handler. It is taken at the first boundary after the return.
- R10: `timer_evt` sets pending line 0. `brk_fault` sets line 1 and `bus_fault` sets line 2, provided that line is unmasked and no handler is active.
- R11: A `brk_fault` or `bus_fault` whose line is masked, or which arrives while a handler is active, sets `halt`. `halt` stays set until reset, and no entry starts while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | N_LINES | External interrupt request lines |
| timer_evt | input | 1 | Timer expiry event (line 0) |
| brk_fault | input | 1 | Break or illegal-instruction fault (line 1) |
| bus_fault | input | 1 | Unaligned-access bus fault (line 2) |
| insn_bound | input | 1 | Instruction boundary strobe |
| cur_pc | input | ADDR_W | Address to resume at if an entry is taken at this boundary |
| take_req | output | 1 | Interrupt entry offered |
| take_ack | input | 1 | Processor accepts the offered entry |
| take_vec | output | ADDR_W | Handler address |
| take_ret | output | ADDR_W | Saved return address |
| take_bits | output | N_LINES | Bitmask of the lines serviced by this entry |
| eoi | output | N_LINES | End-of-interrupt lines for the serviced bits |
| active | output | 1 | Handler offered or running |
| ret_req | input | 1 | Return-from-interrupt request |
| redir_valid | output | 1 | One-cycle redirect to the return address |
| redir_pc | output | ADDR_W | Redirect target |
| mask_we | input | 1 | Mask update strobe |
| mask_wdata | input | N_LINES | New mask value (1 = disabled) |
| mask_rdata | output | N_LINES | Current mask; old value during an update |
| halt | output | 1 | Sticky halt on an unserviceable fault |

## Verification
The bench drives several lines in the same cycle and expects one entry carrying all of them. A priority-encoding design would hand over only one line and re-enter for the rest. A line raised inside the handler must wait and then be taken after the return; a nesting design would re-enter early, and a design that clears all pending bits on entry would lose the line. The bench holds back the acknowledge and sends a return during the offer, which exposes offer values that drift and returns accepted too early. It also checks that a fault on a masked line or inside a handler halts, that a permanently disabled line never shows up, and that randomly masked lines stay pending across many rounds.

// File: rtl/irqc_pkg.sv
// Shared constants and types of the bitmask interrupt controller.
// Assumes at least three lines so the internal sources have a home.
package irqc_pkg;
    localparam int LINE_TIMER = 0;
    localparam int LINE_BRK   = 1;
    localparam int LINE_BUS   = 2;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_OFFER   = 2'd1,
        SQ_HANDLER = 2'd2
    } seq_state_t;
endpackage

// File: rtl/irqc_mask.sv
// Mask register: a 1 disables a line. Resets to all ones. Each write
// ORs in the permanently disabled lines. The output is the register
// itself, so during a write cycle it still shows the old value.
module irqc_mask #(
    parameter int N_LINES = 32,
    parameter logic [N_LINES-1:0] PERM_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [N_LINES-1:0] wr_data,
    output logic [N_LINES-1:0] mask_q
);
    // Hold or replace the mask
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (wr_en)
            mask_q <= wr_data | PERM_MASK;
    end
endmodule

// File: rtl/irqc_pending.sv
// Sticky pending bits plus routing of the internal sources.
// A fault whose line is masked, or which arrives while a handler is
// active, sets a sticky halt instead of a pending bit. Permanently
// disabled lines are held at zero. Bits cleared by an entry are
// removed in the same edge, while new assertions in that cycle survive.
module irqc_pending #(
    parameter int N_LINES = 32,
    parameter logic [N_LINES-1:0] PERM_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req,
    input  logic               timer_evt,
    input  logic               brk_fault,
    input  logic               bus_fault,
    input  logic [N_LINES-1:0] mask_q,
    input  logic               active,
    input  logic               clr_en,
    input  logic [N_LINES-1:0] clr_bits,
    output logic [N_LINES-1:0] pend_q,
    output logic               halt_q
);
    import irqc_pkg::*;

    logic [N_LINES-1:0] set_v;
    logic [N_LINES-1:0] clr_v;
    logic               brk_ok;
    logic               bus_ok;
    logic               halt_set;

    // Collect this cycle's set and clear vectors
    always_comb begin
        brk_ok   = !mask_q[LINE_BRK] && !active;
        bus_ok   = !mask_q[LINE_BUS] && !active;
        set_v    = req;
        set_v[LINE_TIMER] = req[LINE_TIMER] | timer_evt;
        set_v[LINE_BRK]   = req[LINE_BRK] | (brk_fault && brk_ok);
        set_v[LINE_BUS]   = req[LINE_BUS] | (bus_fault && bus_ok);
        halt_set = (brk_fault && !brk_ok) || (bus_fault && !bus_ok);
        clr_v    = clr_en ? clr_bits : '0;
    end

    // One sticky flop per line
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[i] <= 1'b0;
            else
                pend_q[i] <= ((pend_q[i] & ~clr_v[i]) | set_v[i]) & ~PERM_MASK[i];
        end
    end

    // Sticky halt until reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_q <= 1'b0;
        else if (halt_set)
            halt_q <= 1'b1;
    end
endmodule

// File: rtl/irqc_seq.sv
// Entry/return sequencer. Idle -> offer at an eligible boundary,
// offer -> handler on acknowledge, handler -> idle on return. The
// offered values are registered at entry and held until the next entry.
module irqc_seq #(
    parameter int N_LINES = 32,
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 32'h0000_0010,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary,
    input  logic [ADDR_W-1:0]  cur_pc,
    input  logic               take_ack,
    input  logic               ret_req,
    input  logic [N_LINES-1:0] pend_q,
    input  logic [N_LINES-1:0] mask_q,
    input  logic               halt,
    output logic               take_req,
    output logic [ADDR_W-1:0]  take_vec,
    output logic [ADDR_W-1:0]  take_ret,
    output logic [N_LINES-1:0] take_bits,
    output logic [N_LINES-1:0] eoi,
    output logic               active,
    output logic               redir_valid,
    output logic [ADDR_W-1:0]  redir_pc,
    output logic               entry_fire,
    output logic [N_LINES-1:0] entry_bits
);
    import irqc_pkg::*;

    seq_state_t         state_q;
    logic [ADDR_W-1:0]  ret_q;
    logic [N_LINES-1:0] bits_q;

    // Entry decision for this cycle
    always_comb begin
        entry_bits = pend_q & ~mask_q;
        entry_fire = (state_q == SQ_IDLE) && boundary && !halt && (|entry_bits);
    end

    // State, captured entry values and the return pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SQ_IDLE;
            ret_q       <= RESET_ADDR;
            bits_q      <= '0;
            eoi         <= '0;
            redir_valid <= 1'b0;
        end else begin
            redir_valid <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (entry_fire) begin
                        state_q <= SQ_OFFER;
                        ret_q   <= cur_pc;
                        bits_q  <= entry_bits;
                        eoi     <= entry_bits;
                    end
                end
                SQ_OFFER: begin
                    if (take_ack)
                        state_q <= SQ_HANDLER;
                end
                SQ_HANDLER: begin
                    if (ret_req) begin
                        state_q     <= SQ_IDLE;
                        eoi         <= '0;
                        redir_valid <= 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Outputs derived from the state
    always_comb begin
        take_req  = (state_q == SQ_OFFER);
        active    = (state_q != SQ_IDLE);
        take_vec  = HANDLER_ADDR;
        take_ret  = ret_q;
        take_bits = bits_q;
        redir_pc  = ret_q;
    end
endmodule

// File: rtl/irq_bitmask_ctrl.sv
// Top of the bitmask interrupt controller: mask register, pending
// store and entry sequencer. Assumes the processor raises insn_bound
// only between instructions and acknowledges each offer once.
module irq_bitmask_ctrl #(
    parameter int N_LINES = 32,
    parameter int ADDR_W = 32,
    parameter logic [N_LINES-1:0] PERM_MASK = '0,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 32'h0000_0010,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_req,
    input  logic               timer_evt,
    input  logic               brk_fault,
    input  logic               bus_fault,
    input  logic               insn_bound,
    input  logic [ADDR_W-1:0]  cur_pc,
    output logic               take_req,
    input  logic               take_ack,
    output logic [ADDR_W-1:0]  take_vec,
    output logic [ADDR_W-1:0]  take_ret,
    output logic [N_LINES-1:0] take_bits,
    output logic [N_LINES-1:0] eoi,
    output logic               active,
    input  logic               ret_req,
    output logic               redir_valid,
    output logic [ADDR_W-1:0]  redir_pc,
    input  logic               mask_we,
    input  logic [N_LINES-1:0] mask_wdata,
    output logic [N_LINES-1:0] mask_rdata,
    output logic               halt
);
    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] pend_q;
    logic               entry_fire;
    logic [N_LINES-1:0] entry_bits;

    assign mask_rdata = mask_q;

    irqc_mask #(.N_LINES(N_LINES), .PERM_MASK(PERM_MASK)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_we),
        .wr_data (mask_wdata),
        .mask_q  (mask_q)
    );

    irqc_pending #(.N_LINES(N_LINES), .PERM_MASK(PERM_MASK)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (irq_req),
        .timer_evt (timer_evt),
        .brk_fault (brk_fault),
        .bus_fault (bus_fault),
        .mask_q    (mask_q),
        .active    (active),
        .clr_en    (entry_fire),
        .clr_bits  (entry_bits),
        .pend_q    (pend_q),
        .halt_q    (halt)
    );

    irqc_seq #(
        .N_LINES(N_LINES), .ADDR_W(ADDR_W),
        .HANDLER_ADDR(HANDLER_ADDR), .RESET_ADDR(RESET_ADDR)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary    (insn_bound),
        .cur_pc      (cur_pc),
        .take_ack    (take_ack),
        .ret_req     (ret_req),
        .pend_q      (pend_q),
        .mask_q      (mask_q),
        .halt        (halt),
        .take_req    (take_req),
        .take_vec    (take_vec),
        .take_ret    (take_ret),
        .take_bits   (take_bits),
        .eoi         (eoi),
        .active      (active),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .entry_fire  (entry_fire),
        .entry_bits  (entry_bits)
    );
endmodule

// File: rtl/irqc_chk.sv
// Protocol checker for irq_bitmask_ctrl, attached by bind. It only
// observes ports and relates them across cycles.
module irqc_chk #(
    parameter int N_LINES = 32,
    parameter int ADDR_W = 32,
    parameter logic [N_LINES-1:0] PERM_MASK = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               take_req,
    input logic               take_ack,
    input logic [ADDR_W-1:0]  take_ret,
    input logic [N_LINES-1:0] take_bits,
    input logic [N_LINES-1:0] eoi,
    input logic               active,
    input logic               ret_req,
    input logic               redir_valid,
    input logic               mask_we,
    input logic [N_LINES-1:0] mask_wdata,
    input logic [N_LINES-1:0] mask_rdata,
    input logic               halt
);
    // R3: permanently disabled lines never reach end-of-interrupt
    p_perm_never_serviced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi & PERM_MASK) == '0);

    // R4: the handler becomes active only through an offer
    p_active_via_offer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> take_req);

    // R5: a fresh offer carries a nonzero bitmask mirrored on eoi
    p_offer_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_req) |-> (eoi == take_bits) && (take_bits != '0));

    // R6: a mask write lands as data OR the permanent lines
    p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_rdata == ($past(mask_wdata) | PERM_MASK));

    // R7: an unacknowledged offer holds still
    p_offer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && !take_ack) |=> take_req && $stable(take_bits) && $stable(take_ret));

    // R8: a return inside the handler releases it
    p_return_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !take_req && ret_req) |=> (eoi == '0) && !active && redir_valid);

    // R11: halt is sticky
    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);
endmodule

bind irq_bitmask_ctrl irqc_chk #(
    .N_LINES(N_LINES), .ADDR_W(ADDR_W), .PERM_MASK(PERM_MASK)
) u_irqc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_req    (take_req),
    .take_ack    (take_ack),
    .take_ret    (take_ret),
    .take_bits   (take_bits),
    .eoi         (eoi),
    .active      (active),
    .ret_req     (ret_req),
    .redir_valid (redir_valid),
    .mask_we     (mask_we),
    .mask_wdata  (mask_wdata),
    .mask_rdata  (mask_rdata),
    .halt        (halt)
);

// File: tb/tb_irq_bitmask_ctrl.sv
// Self-checking bench: directed corner cases, then seeded random rounds
// checked against a bench-side model of pending and mask.
module tb_irq_bitmask_ctrl;
    localparam int CLK_P = 10;
    localparam logic [31:0] PERM = 32'h8000_0000;
    localparam logic [31:0] HVEC = 32'h0000_0010;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_req, cur_pc, take_vec, take_ret, take_bits, eoi;
    logic [31:0] redir_pc, mask_wdata, mask_rdata;
    logic        timer_evt, brk_fault, bus_fault, insn_bound, take_req, take_ack;
    logic        active, ret_req, redir_valid, mask_we, halt;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_pend, m_mask;

    always #(CLK_P/2) clk = ~clk;

    irq_bitmask_ctrl #(.PERM_MASK(PERM)) dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .timer_evt(timer_evt),
        .brk_fault(brk_fault), .bus_fault(bus_fault), .insn_bound(insn_bound),
        .cur_pc(cur_pc), .take_req(take_req), .take_ack(take_ack),
        .take_vec(take_vec), .take_ret(take_ret), .take_bits(take_bits),
        .eoi(eoi), .active(active), .ret_req(ret_req), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .mask_rdata(mask_rdata), .halt(halt)
    );

    function automatic logic [31:0] expect_entry(logic [31:0] p, logic [31:0] m);
        return p & ~m;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // advance one edge, then settle just past it
    task automatic tick();
        @(posedge clk);
        #1;
        irq_req = '0; timer_evt = 0; brk_fault = 0; bus_fault = 0;
        insn_bound = 0; take_ack = 0; ret_req = 0; mask_we = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        irq_req = '0; timer_evt = 0; brk_fault = 0; bus_fault = 0;
        insn_bound = 0; take_ack = 0; ret_req = 0; mask_we = 0;
        mask_wdata = '0; cur_pc = '0;
        repeat (3) tick();
        rst_n = 1;
        m_pend = '0; m_mask = '1;
    endtask

    task automatic write_mask(logic [31:0] v);
        mask_we = 1; mask_wdata = v;
        #1 chk("R6 old mask during write", mask_rdata, m_mask);
        tick();
        m_mask = v | PERM;
        chk("R6 new mask", mask_rdata, m_mask);
    endtask

    task automatic pulse_req(logic [31:0] r);
        irq_req = r;
        tick();
        m_pend |= r & ~PERM;
    endtask

    // boundary at pc; verify entry or no entry against the model
    task automatic boundary(logic [31:0] pc, string tag);
        logic [31:0] exp;
        exp = expect_entry(m_pend, m_mask);
        insn_bound = 1; cur_pc = pc;
        tick();
        if (exp != 0) begin
            chk({tag, " R4 take_req"}, {31'd0, take_req}, 32'd1);
            chk({tag, " R5 take_bits"}, take_bits, exp);
            chk({tag, " R5 eoi"}, eoi, exp);
            chk({tag, " R7 take_ret"}, take_ret, pc);
            chk({tag, " R7 take_vec"}, take_vec, HVEC);
            m_pend &= ~exp;
        end else begin
            chk({tag, " R4 no entry"}, {31'd0, take_req}, 32'd0);
        end
    endtask

    task automatic ack_and_return(logic [31:0] pc, string tag);
        take_ack = 1;
        tick();
        chk({tag, " R7 offer ends"}, {30'd0, take_req, active}, 32'd1);
        ret_req = 1;
        tick();
        chk({tag, " R8 redir_valid"}, {31'd0, redir_valid}, 32'd1);
        chk({tag, " R8 redir_pc"}, redir_pc, pc);
        chk({tag, " R8 eoi cleared"}, eoi, 32'd0);
        chk({tag, " R8 inactive"}, {31'd0, active}, 32'd0);
        tick();
        chk({tag, " R8 single pulse"}, {31'd0, redir_valid}, 32'd0);
    endtask

    initial begin
        #(CLK_P * 50000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R2: reset state
        chk("R2 mask all ones", mask_rdata, 32'hFFFF_FFFF);
        chk("R2 outputs idle", {27'd0, take_req, active, halt, redir_valid, |eoi}, 32'd0);
        chk("R2 redir_pc", redir_pc, 32'd0);

        // R1/R4: masked line stays pending, entry needs a boundary
        pulse_req(32'h0000_0008);
        boundary(32'h100, "masked");
        write_mask(32'h0);
        chk("R3 perm bit forced", mask_rdata, PERM);
        tick(); tick();
        chk("R4 no boundary no entry", {31'd0, take_req}, 32'd0);
        boundary(32'h104, "R1 sticky");
        ack_and_return(32'h104, "first");

        // R5/R3: several lines at once, one entry, perm line dropped
        pulse_req(32'h8010_0090);
        boundary(32'h200, "multi");
        tick(); tick();
        chk("R7 held bits", take_bits, 32'h0010_0090);
        chk("R7 held ret", take_ret, 32'h200);
        ret_req = 1;
        tick();
        chk("R8 return during offer ignored", {30'd0, take_req, redir_valid}, 32'd2);
        take_ack = 1;
        tick();
        // R9: line raised inside handler waits
        pulse_req(32'h0000_0200);
        insn_bound = 1; cur_pc = 32'h300;
        tick();
        chk("R9 no nested entry", {30'd0, take_req, active}, 32'd1);
        ret_req = 1;
        tick();
        chk("R9 return to 0x200", redir_pc, 32'h200);
        boundary(32'h204, "R9 after return");
        ack_and_return(32'h204, "r9");

        // R8: return while idle ignored
        ret_req = 1;
        tick();
        chk("R8 idle return ignored", {30'd0, redir_valid, active}, 32'd0);

        // R10: internal sources
        timer_evt = 1; bus_fault = 1;
        tick();
        m_pend |= 32'h5;
        boundary(32'h400, "R10 timer+bus");
        ack_and_return(32'h400, "r10a");
        brk_fault = 1;
        tick();
        m_pend |= 32'h2;
        boundary(32'h404, "R10 break");
        ack_and_return(32'h404, "r10b");
        chk("R10 no halt", {31'd0, halt}, 32'd0);

        // R11: fault on masked line halts, sticky, blocks entry
        write_mask(32'h2);
        brk_fault = 1;
        tick();
        chk("R11 halt on masked fault", {31'd0, halt}, 32'd1);
        pulse_req(32'h40);
        insn_bound = 1;
        tick(); tick();
        chk("R11 halt blocks entry", {31'd0, take_req}, 32'd0);
        chk("R11 halt sticky", {31'd0, halt}, 32'd1);

        // R11: fault during handler halts
        do_reset();
        chk("R2 halt cleared", {31'd0, halt}, 32'd0);
        write_mask(32'h0);
        pulse_req(32'h20);
        boundary(32'h500, "pre-fault");
        take_ack = 1;
        tick();
        bus_fault = 1;
        tick();
        chk("R11 halt in handler", {31'd0, halt}, 32'd1);

        // random rounds against the model
        do_reset();
        for (int k = 0; k < 60; k++) begin
            logic [31:0] pc;
            write_mask($urandom & $urandom);
            pulse_req($urandom & $urandom & $urandom);
            if ($urandom % 3 == 0) pulse_req($urandom & $urandom);
            pc = $urandom & 32'hFFFF_FFFC;
            boundary(pc, "rand");
            if (take_req) ack_and_return(pc, "rand");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule